// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block derives a complete set of raster timing strobes from a single pixel clock: horizontal and vertical sync, horizontal and vertical blank, composite sync and composite blank, two drive outputs and an odd/even field flag. Two free-running counters set the timing. One counts pixels within a line and the other counts half-lines within a field. Every edge is a programmable end-count that is compared against one of these counters. Nothing in the timing is fixed apart from the relationships between the counters.

A configuration snapshot is presented on the `cfg_*` inputs and captured as a whole when `cfg_we` is pulsed. A synchronous clear zeroes both counters and reloads RS-170 timing for a 14.31818 MHz clock: 910 clocks per line, front porch ending at 23, sync ending at 91, blank ending at 157, and 525 half-lines per field (interlaced). A run bit gates the counters. The parameter `RUN_AT_CLEAR` chooses whether a clear leaves the generator stopped, which allows reprogramming first, or running on the defaults at once.

Interlace follows from the field length. An odd number of half-lines makes successive fields start alternately on a line boundary and at mid-line. When enabled, composite sync carries half-line equalization pulses around the vertical sync and serration pulses within it. In gate mode, the two drive outputs show programmable horizontal and vertical windows, usable as gating pulses or a cursor position, in place of plain sync.

Top module: `raster_sync_gen`

## Requirements
- R1: While `clr` is high, every output goes low on the next edge, both counters return to zero, the odd flag clears and the default configuration is loaded.
- R2: With `RUN_AT_CLEAR`=0 the run bit is 0 after a clear, so the counters hold and `hsync_o` stays low until a configuration with run set is loaded.
- R3: With `RUN_AT_CLEAR`=1 the defaults run straight after clear: counting from the first edge with `clr` low as edge 0, `hsync_o` is first seen high after edge 23, is high for 68 clocks and rises again 910 clocks later.
- R4: The pixel counter runs from 0 to `h_total`-1 and then wraps to 0. It also wraps on the next edge if a smaller `h_total` is loaded while the counter is already at or beyond the new last count.
- R5: `hblank_o` is high for pixel counts below `h_blank_end`, and `hsync_o` is high for counts from `h_fp_end` up to but not including `h_sync_end`. Each output reflects the counter value held one edge earlier.
- R6: The vertical counter advances at pixel counts `h_total`/2-1 and `h_total`-1 and wraps after `v_total` half-lines. `vblank_o` is high below `v_blank_end`, and `vsync_o` is high from `v_fp_end` up to but not including `v_sync_end`.
- R7: The odd flag toggles whenever the vertical counter wraps with interlace set. It never changes while interlace is clear.
- R8: With equalization off, `csync_o` equals `hsync` XOR `vsync`.
- R9: With equalization on, let hp be the pixel count folded into one half-line. Inside the vertical sync window, `csync_o` is low for hp in [`h_fp_end`, `h_sync_end`) and high elsewhere. Within `v_eq_len` half-lines before or after that window, `csync_o` is high for hp in [`h_fp_end`, `h_fp_end`+(`h_sync_end`-`h_fp_end`)/2). Everywhere else it follows hsync.
- R10: `cblank_o` is the OR of horizontal and vertical blank.
- R11: With gate mode off, `hdrv_o` and `vdrv_o` repeat hsync and vsync. With gate mode on, they are high for pixel count in [`h_gate_beg`, `h_gate_end`) and half-line count in [`v_gate_beg`, `v_gate_end`) respectively.
- R12: While run is 0 both counters hold, so the outputs stay constant when the configuration is left unchanged.
- R13: A high `cfg_we` captures every `cfg_*` input at that edge. `cfg_status` bit 0 is run, bit 1 interlace, bit 2 equalization enable and bit 3 gate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| clr | input | 1 | Synchronous clear, active high |
| cfg_we | input | 1 | Capture the configuration snapshot |
| cfg_status | input | 4 | {gate mode, equalization, interlace, run} |
| cfg_h_total | input | 12 | Clocks per line |
| cfg_h_fp_end | input | 12 | Front porch end / sync start count |
| cfg_h_sync_end | input | 12 | Horizontal sync end count |
| cfg_h_blank_end | input | 12 | Horizontal blank end count |
| cfg_h_gate_beg | input | 12 | Horizontal gate start count |
| cfg_h_gate_end | input | 12 | Horizontal gate end count |
| cfg_v_total | input | 11 | Half-lines per field |
| cfg_v_fp_end | input | 11 | Vertical sync start, in half-lines |
| cfg_v_sync_end | input | 11 | Vertical sync end, in half-lines |
| cfg_v_blank_end | input | 11 | Vertical blank end, in half-lines |
| cfg_v_eq_len | input | 11 | Equalization span on each side of vertical sync |
| cfg_v_gate_beg | input | 11 | Vertical gate start, in half-lines |
| cfg_v_gate_end | input | 11 | Vertical gate end, in half-lines |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| csync_o | output | 1 | Composite sync |
| cblank_o | output | 1 | Composite blank |
| hdrv_o | output | 1 | Horizontal drive or gate |
| vdrv_o | output | 1 | Vertical drive or gate |
| odd_field_o | output | 1 | Field parity flag |

## Verification
The assertions check the following on every cycle: that the counters hold while run is low, that the pixel counter wraps from its last count, that the composite blank is the union of the two blanks, that field parity never moves unless interlace was set, and that a clear leaves zeroed counters and quiet outputs. Some behaviour can only be shown by the bench's scenarios, because it depends on the programmed edge positions: the exact cycle of each sync and blank edge, the half-line placement of equalization and serration pulses, the gate windows, and the RS-170 start-up of the run-at-clear variant. Randomized configurations, including ones loaded mid-line with a shorter line, exercise these against an independent model.

// File: rtl/sync_pkg.sv
package sync_pkg;

    localparam int HCNT_W = 12;
    localparam int VCNT_W = 11;
    localparam int ST_W   = 4;

    typedef logic [HCNT_W-1:0] hcnt_t;
    typedef logic [VCNT_W-1:0] vcnt_t;

    typedef struct packed {
        logic gate_mode;
        logic eq_en;
        logic interlace;
        logic run;
    } status_t;

    typedef struct packed {
        hcnt_t total;
        hcnt_t fp_end;
        hcnt_t sync_end;
        hcnt_t blank_end;
        hcnt_t gate_beg;
        hcnt_t gate_end;
    } hcfg_t;

    typedef struct packed {
        vcnt_t total;
        vcnt_t fp_end;
        vcnt_t sync_end;
        vcnt_t blank_end;
        vcnt_t eq_len;
        vcnt_t gate_beg;
        vcnt_t gate_end;
    } vcfg_t;

    typedef struct packed {
        status_t st;
        hcfg_t   h;
        vcfg_t   v;
    } cfg_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic hblank;
        logic vblank;
        logic csync;
        logic cblank;
        logic hdrv;
        logic vdrv;
        logic odd;
    } sync_out_t;

    // RS-170 timing at a 14.31818 MHz pixel clock
    function automatic cfg_t default_cfg(input logic run_bit);
        cfg_t c;
        c.st.gate_mode = 1'b0;
        c.st.eq_en     = 1'b1;
        c.st.interlace = 1'b1;
        c.st.run       = run_bit;
        c.h.total      = hcnt_t'(910);
        c.h.fp_end     = hcnt_t'(23);
        c.h.sync_end   = hcnt_t'(91);
        c.h.blank_end  = hcnt_t'(157);
        c.h.gate_beg   = hcnt_t'(0);
        c.h.gate_end   = hcnt_t'(157);
        c.v.total      = vcnt_t'(525);
        c.v.fp_end     = vcnt_t'(6);
        c.v.sync_end   = vcnt_t'(12);
        c.v.blank_end  = vcnt_t'(40);
        c.v.eq_len     = vcnt_t'(6);
        c.v.gate_beg   = vcnt_t'(0);
        c.v.gate_end   = vcnt_t'(40);
        return c;
    endfunction

    function automatic logic in_span_h(input hcnt_t x, input hcnt_t lo, input hcnt_t hi);
        return (x >= lo) && (x < hi);
    endfunction

    function automatic logic in_span_v(input vcnt_t x, input vcnt_t lo, input vcnt_t hi);
        return (x >= lo) && (x < hi);
    endfunction

endpackage

// File: rtl/sync_cfg_reg.sv
module sync_cfg_reg
    import sync_pkg::*;
#(
    parameter bit RUN_AT_CLEAR = 1'b0
) (
    input  logic clk,
    input  logic clr,
    input  logic we,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            cfg_q <= default_cfg(RUN_AT_CLEAR);
        end else if (we) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/sync_counters.sv
module sync_counters
    import sync_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  run,
    input  logic  interlace,
    input  hcnt_t h_total,
    input  vcnt_t v_total,
    output hcnt_t hc,
    output vcnt_t vc,
    output logic  odd
);

    hcnt_t h_half;
    logic  h_last;
    logic  v_last;
    logic  half_tick;

    always_comb begin
        h_half    = h_total >> 1;
        h_last    = (hc >= h_total - hcnt_t'(1));
        v_last    = (vc >= v_total - vcnt_t'(1));
        half_tick = h_last || (hc == h_half - hcnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            hc  <= '0;
            vc  <= '0;
            odd <= 1'b0;
        end else if (run) begin
            hc <= h_last ? '0 : hc + hcnt_t'(1);
            if (half_tick) begin
                vc <= v_last ? '0 : vc + vcnt_t'(1);
                if (v_last && interlace) begin
                    odd <= ~odd;
                end
            end
        end
    end

endmodule

// File: rtl/sync_decode.sv
module sync_decode
    import sync_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      eq_en,
    input  logic      gate_mode,
    input  hcfg_t     h,
    input  vcnt_t     v_fp_end,
    input  vcnt_t     v_sync_end,
    input  vcnt_t     v_blank_end,
    input  vcnt_t     v_eq_len,
    input  vcnt_t     v_gate_beg,
    input  vcnt_t     v_gate_end,
    input  hcnt_t     hc,
    input  vcnt_t     vc,
    input  logic      odd,
    output sync_out_t out_q
);

    localparam int HX_W = HCNT_W + 1;
    localparam int VX_W = VCNT_W + 1;

    hcnt_t     h_half;
    hcnt_t     hp;
    hcnt_t     eq_w;
    logic [HX_W-1:0] eq_hi;
    logic [VX_W-1:0] pre_reach;
    logic [VX_W-1:0] post_hi;
    logic      hs, vs, hb, vb;
    logic      eq_pulse, serr, in_pre, in_post;
    sync_out_t nxt;

    always_comb begin
        h_half   = h.total >> 1;
        hp       = (hc >= h_half) ? hc - h_half : hc;
        eq_w     = (h.sync_end - h.fp_end) >> 1;
        eq_hi    = {1'b0, h.fp_end} + {1'b0, eq_w};

        hs       = in_span_h(hc, h.fp_end, h.sync_end);
        hb       = (hc < h.blank_end);
        vs       = in_span_v(vc, v_fp_end, v_sync_end);
        vb       = (vc < v_blank_end);

        eq_pulse = (hp >= h.fp_end) && ({1'b0, hp} < eq_hi);
        serr     = !in_span_h(hp, h.fp_end, h.sync_end);

        pre_reach = {1'b0, vc} + {1'b0, v_eq_len};
        post_hi   = {1'b0, v_sync_end} + {1'b0, v_eq_len};
        in_pre    = (pre_reach >= {1'b0, v_fp_end}) && (vc < v_fp_end);
        in_post   = (vc >= v_sync_end) && ({1'b0, vc} < post_hi);

        nxt.hsync  = hs;
        nxt.vsync  = vs;
        nxt.hblank = hb;
        nxt.vblank = vb;
        nxt.cblank = hb | vb;
        nxt.odd    = odd;

        if (!eq_en) begin
            nxt.csync = hs ^ vs;
        end else if (vs) begin
            nxt.csync = serr;
        end else if (in_pre || in_post) begin
            nxt.csync = eq_pulse;
        end else begin
            nxt.csync = hs;
        end

        if (gate_mode) begin
            nxt.hdrv = in_span_h(hc, h.gate_beg, h.gate_end);
            nxt.vdrv = in_span_v(vc, v_gate_beg, v_gate_end);
        end else begin
            nxt.hdrv = hs;
            nxt.vdrv = vs;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import sync_pkg::*;
#(
    parameter bit RUN_AT_CLEAR = 1'b0
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              cfg_we,
    input  logic [ST_W-1:0]   cfg_status,
    input  logic [HCNT_W-1:0] cfg_h_total,
    input  logic [HCNT_W-1:0] cfg_h_fp_end,
    input  logic [HCNT_W-1:0] cfg_h_sync_end,
    input  logic [HCNT_W-1:0] cfg_h_blank_end,
    input  logic [HCNT_W-1:0] cfg_h_gate_beg,
    input  logic [HCNT_W-1:0] cfg_h_gate_end,
    input  logic [VCNT_W-1:0] cfg_v_total,
    input  logic [VCNT_W-1:0] cfg_v_fp_end,
    input  logic [VCNT_W-1:0] cfg_v_sync_end,
    input  logic [VCNT_W-1:0] cfg_v_blank_end,
    input  logic [VCNT_W-1:0] cfg_v_eq_len,
    input  logic [VCNT_W-1:0] cfg_v_gate_beg,
    input  logic [VCNT_W-1:0] cfg_v_gate_end,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              hblank_o,
    output logic              vblank_o,
    output logic              csync_o,
    output logic              cblank_o,
    output logic              hdrv_o,
    output logic              vdrv_o,
    output logic              odd_field_o
);

    cfg_t      cfg_in;
    cfg_t      cfg_q;
    hcnt_t     hc;
    vcnt_t     vc;
    logic      odd;
    sync_out_t outs;

    always_comb begin
        cfg_in.st          = status_t'(cfg_status);
        cfg_in.h.total     = cfg_h_total;
        cfg_in.h.fp_end    = cfg_h_fp_end;
        cfg_in.h.sync_end  = cfg_h_sync_end;
        cfg_in.h.blank_end = cfg_h_blank_end;
        cfg_in.h.gate_beg  = cfg_h_gate_beg;
        cfg_in.h.gate_end  = cfg_h_gate_end;
        cfg_in.v.total     = cfg_v_total;
        cfg_in.v.fp_end    = cfg_v_fp_end;
        cfg_in.v.sync_end  = cfg_v_sync_end;
        cfg_in.v.blank_end = cfg_v_blank_end;
        cfg_in.v.eq_len    = cfg_v_eq_len;
        cfg_in.v.gate_beg  = cfg_v_gate_beg;
        cfg_in.v.gate_end  = cfg_v_gate_end;
    end

    sync_cfg_reg #(.RUN_AT_CLEAR(RUN_AT_CLEAR)) u_cfg (
        .clk    (clk),
        .clr    (clr),
        .we     (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    sync_counters u_cnt (
        .clk       (clk),
        .clr       (clr),
        .run       (cfg_q.st.run),
        .interlace (cfg_q.st.interlace),
        .h_total   (cfg_q.h.total),
        .v_total   (cfg_q.v.total),
        .hc        (hc),
        .vc        (vc),
        .odd       (odd)
    );

    sync_decode u_dec (
        .clk         (clk),
        .clr         (clr),
        .eq_en       (cfg_q.st.eq_en),
        .gate_mode   (cfg_q.st.gate_mode),
        .h           (cfg_q.h),
        .v_fp_end    (cfg_q.v.fp_end),
        .v_sync_end  (cfg_q.v.sync_end),
        .v_blank_end (cfg_q.v.blank_end),
        .v_eq_len    (cfg_q.v.eq_len),
        .v_gate_beg  (cfg_q.v.gate_beg),
        .v_gate_end  (cfg_q.v.gate_end),
        .hc          (hc),
        .vc          (vc),
        .odd         (odd),
        .out_q       (outs)
    );

    assign hsync_o     = outs.hsync;
    assign vsync_o     = outs.vsync;
    assign hblank_o    = outs.hblank;
    assign vblank_o    = outs.vblank;
    assign csync_o     = outs.csync;
    assign cblank_o    = outs.cblank;
    assign hdrv_o      = outs.hdrv;
    assign vdrv_o      = outs.vdrv;
    assign odd_field_o = outs.odd;

endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk
    import sync_pkg::*;
(
    input logic  clk,
    input logic  clr,
    input logic  run,
    input logic  interlace,
    input hcnt_t h_total,
    input hcnt_t hc,
    input vcnt_t vc,
    input logic  odd,
    input logic  hsync_o,
    input logic  vsync_o,
    input logic  hblank_o,
    input logic  vblank_o,
    input logic  csync_o,
    input logic  cblank_o,
    input logic  hdrv_o,
    input logic  vdrv_o,
    input logic  odd_field_o
);

    // R1: leaving clear shows zeroed counters and quiet outputs
    a_r1_clear_state: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> (hc == '0 && vc == '0 && !odd &&
                        !hsync_o && !vsync_o && !hblank_o && !vblank_o &&
                        !csync_o && !cblank_o && !hdrv_o && !vdrv_o && !odd_field_o));

    // R4: pixel counter wraps from its last count
    a_r4_line_wrap: assert property (@(posedge clk) disable iff (clr)
        (run && hc >= h_total - hcnt_t'(1)) |=> (hc == '0));

    // R12: counters hold while stopped
    a_r12_hold: assert property (@(posedge clk) disable iff (clr)
        !run |=> ($stable(hc) && $stable(vc)));

    // R10: composite blank is the union of both blanks
    a_r10_cblank_union: assert property (@(posedge clk) disable iff (clr)
        cblank_o == (hblank_o | vblank_o));

    // R7: parity moves only when interlace was set
    a_r7_odd_needs_interlace: assert property (@(posedge clk) disable iff (clr)
        ((odd != $past(odd)) && !$past(clr)) |-> $past(interlace));

endmodule

bind raster_sync_gen raster_sync_gen_chk u_chk (
    .clk         (clk),
    .clr         (clr),
    .run         (cfg_q.st.run),
    .interlace   (cfg_q.st.interlace),
    .h_total     (cfg_q.h.total),
    .hc          (hc),
    .vc          (vc),
    .odd         (odd),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .hblank_o    (hblank_o),
    .vblank_o    (vblank_o),
    .csync_o     (csync_o),
    .cblank_o    (cblank_o),
    .hdrv_o      (hdrv_o),
    .vdrv_o      (vdrv_o),
    .odd_field_o (odd_field_o)
);

// File: tb/raster_sync_gen_tb.sv
`timescale 1ns/1ps
module raster_sync_gen_tb;
    import sync_pkg::*;

    typedef struct {
        int ht, hf, hs, hb, hgb, hge;
        int vt, vf, vs, vb, ve, vgb, vge;
        bit run, il, eq, gm;
    } mcfg_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic clr = 1'b1;
    logic we  = 1'b0;
    logic [ST_W-1:0] st;
    hcnt_t h_tot, h_fp, h_sy, h_bl, h_gb, h_ge;
    vcnt_t v_tot, v_fp, v_sy, v_bl, v_eq, v_gb, v_ge;

    logic a_hs, a_vs, a_hb, a_vb, a_cs, a_cb, a_hd, a_vd, a_od;
    logic b_hs, b_vs, b_hb, b_vb, b_cs, b_cb, b_hd, b_vd, b_od;

    raster_sync_gen u_dut (
        .clk(clk), .clr(clr), .cfg_we(we), .cfg_status(st),
        .cfg_h_total(h_tot), .cfg_h_fp_end(h_fp), .cfg_h_sync_end(h_sy),
        .cfg_h_blank_end(h_bl), .cfg_h_gate_beg(h_gb), .cfg_h_gate_end(h_ge),
        .cfg_v_total(v_tot), .cfg_v_fp_end(v_fp), .cfg_v_sync_end(v_sy),
        .cfg_v_blank_end(v_bl), .cfg_v_eq_len(v_eq), .cfg_v_gate_beg(v_gb),
        .cfg_v_gate_end(v_ge),
        .hsync_o(a_hs), .vsync_o(a_vs), .hblank_o(a_hb), .vblank_o(a_vb),
        .csync_o(a_cs), .cblank_o(a_cb), .hdrv_o(a_hd), .vdrv_o(a_vd),
        .odd_field_o(a_od)
    );

    raster_sync_gen #(.RUN_AT_CLEAR(1'b1)) u_dut_r (
        .clk(clk), .clr(clr), .cfg_we(we), .cfg_status(st),
        .cfg_h_total(h_tot), .cfg_h_fp_end(h_fp), .cfg_h_sync_end(h_sy),
        .cfg_h_blank_end(h_bl), .cfg_h_gate_beg(h_gb), .cfg_h_gate_end(h_ge),
        .cfg_v_total(v_tot), .cfg_v_fp_end(v_fp), .cfg_v_sync_end(v_sy),
        .cfg_v_blank_end(v_bl), .cfg_v_eq_len(v_eq), .cfg_v_gate_beg(v_gb),
        .cfg_v_gate_end(v_ge),
        .hsync_o(b_hs), .vsync_o(b_vs), .hblank_o(b_hb), .vblank_o(b_vb),
        .csync_o(b_cs), .cblank_o(b_cb), .hdrv_o(b_hd), .vdrv_o(b_vd),
        .odd_field_o(b_od)
    );

    wire [8:0] got_a = {a_hs, a_vs, a_hb, a_vb, a_cs, a_cb, a_hd, a_vd, a_od};
    wire [8:0] got_b = {b_hs, b_vs, b_hb, b_vb, b_cs, b_cb, b_hd, b_vd, b_od};

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    int    k      = 0;
    int    m_hc   = 0;
    int    m_vc   = 0;
    bit    m_odd  = 1'b0;
    logic [8:0] m_out = '0;
    mcfg_t m_cfg;
    mcfg_t drv;

    function automatic mcfg_t dflt(input bit r);
        mcfg_t c;
        c.ht = 910; c.hf = 23; c.hs = 91; c.hb = 157; c.hgb = 0; c.hge = 157;
        c.vt = 525; c.vf = 6;  c.vs = 12; c.vb = 40;  c.ve = 6;  c.vgb = 0; c.vge = 40;
        c.run = r; c.il = 1'b1; c.eq = 1'b1; c.gm = 1'b0;
        return c;
    endfunction

    // expected outputs from the requirement text, bit order as got_a
    function automatic logic [8:0] ref_out(input int hc, input int vc, input bit odd, input mcfg_t c);
        bit hs, vs, hb, vb, cs, hd, vd, eqp, ser, pre, post;
        int half, hp, eqw;
        hs   = (hc >= c.hf) && (hc < c.hs);
        hb   = hc < c.hb;
        vs   = (vc >= c.vf) && (vc < c.vs);
        vb   = vc < c.vb;
        half = c.ht / 2;
        hp   = (hc >= half) ? hc - half : hc;
        eqw  = (c.hs - c.hf) / 2;
        eqp  = (hp >= c.hf) && (hp < c.hf + eqw);
        ser  = !((hp >= c.hf) && (hp < c.hs));
        pre  = (vc + c.ve >= c.vf) && (vc < c.vf);
        post = (vc >= c.vs) && (vc < c.vs + c.ve);
        if (!c.eq)           cs = hs ^ vs;
        else if (vs)         cs = ser;
        else if (pre || post) cs = eqp;
        else                 cs = hs;
        hd = c.gm ? ((hc >= c.hgb) && (hc < c.hge)) : hs;
        vd = c.gm ? ((vc >= c.vgb) && (vc < c.vge)) : vs;
        return {hs, vs, hb, vb, cs, hb | vb, hd, vd, odd};
    endfunction

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", tag, k, got, exp);
        end
    endtask

    task automatic apply_inputs();
        st    = {drv.gm, drv.eq, drv.il, drv.run};
        h_tot = hcnt_t'(drv.ht);  h_fp = hcnt_t'(drv.hf);  h_sy = hcnt_t'(drv.hs);
        h_bl  = hcnt_t'(drv.hb);  h_gb = hcnt_t'(drv.hgb); h_ge = hcnt_t'(drv.hge);
        v_tot = vcnt_t'(drv.vt);  v_fp = vcnt_t'(drv.vf);  v_sy = vcnt_t'(drv.vs);
        v_bl  = vcnt_t'(drv.vb);  v_eq = vcnt_t'(drv.ve);  v_gb = vcnt_t'(drv.vgb);
        v_ge  = vcnt_t'(drv.vge);
    endtask

    task automatic model_edge();
        int  half;
        bit  hl, tick_v;
        if (clr) begin
            m_out = '0; m_hc = 0; m_vc = 0; m_odd = 1'b0; m_cfg = dflt(1'b0);
        end else begin
            m_out = ref_out(m_hc, m_vc, m_odd, m_cfg);
            if (m_cfg.run) begin
                half   = m_cfg.ht / 2;
                hl     = m_hc >= m_cfg.ht - 1;
                tick_v = hl || (m_hc == half - 1);
                m_hc   = hl ? 0 : m_hc + 1;
                if (tick_v) begin
                    if (m_vc >= m_cfg.vt - 1) begin
                        m_vc = 0;
                        if (m_cfg.il) m_odd = ~m_odd;
                    end else begin
                        m_vc = m_vc + 1;
                    end
                end
            end
            if (we) m_cfg = drv;
        end
    endtask

    task automatic compare_model();
        string cs_tag;
        cs_tag = m_cfg.eq ? "R9 csync" : "R8 csync";
        check(got_a[8] == m_out[8], "R5 R13 hsync",  got_a[8], m_out[8]);
        check(got_a[7] == m_out[7], "R6 vsync",      got_a[7], m_out[7]);
        check(got_a[6] == m_out[6], "R4 R5 hblank",  got_a[6], m_out[6]);
        check(got_a[5] == m_out[5], "R6 vblank",     got_a[5], m_out[5]);
        check(got_a[4] == m_out[4], cs_tag,          got_a[4], m_out[4]);
        check(got_a[3] == m_out[3], "R10 cblank",    got_a[3], m_out[3]);
        check(got_a[2] == m_out[2], "R11 hdrv",      got_a[2], m_out[2]);
        check(got_a[1] == m_out[1], "R11 vdrv",      got_a[1], m_out[1]);
        check(got_a[0] == m_out[0], "R7 odd",        got_a[0], m_out[0]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_model();
        k++;
    endtask

    function automatic mcfg_t rand_cfg();
        mcfg_t c;
        c.ht  = 16 + int'($urandom % 32);
        c.hf  = 1 + int'($urandom % (c.ht / 4));
        c.hs  = c.hf + 2 + int'($urandom % (c.ht / 4));
        c.hb  = c.hs + 1 + int'($urandom % 4);
        c.hgb = int'($urandom % c.ht);
        c.hge = int'($urandom % (c.ht + 1));
        c.ve  = 1 + int'($urandom % 3);
        c.vf  = c.ve + int'($urandom % 3);
        c.vs  = c.vf + 1 + int'($urandom % 3);
        c.vb  = c.vs + c.ve + int'($urandom % 4);
        c.vt  = c.vb + 2 + int'($urandom % 12);
        c.vgb = int'($urandom % c.vt);
        c.vge = int'($urandom % (c.vt + 1));
        c.run = 1'b1;
        c.il  = 1'($urandom % 2);
        c.eq  = 1'($urandom % 2);
        c.gm  = 1'($urandom % 2);
        return c;
    endfunction

    task automatic load(input mcfg_t c);
        drv = c;
        apply_inputs();
        we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int first_rise, first_fall, second_rise;
        logic [8:0] held;
        void'($urandom(32'd715));
        m_cfg = dflt(1'b0);
        drv   = dflt(1'b0);
        apply_inputs();
        @(negedge clk);

        // R1: outputs low during clear, both variants
        for (int i = 0; i < 3; i++) begin
            tick();
            check(got_a == '0, "R1 clear outputs base", got_a, 0);
            check(got_b == '0, "R1 clear outputs run-variant", got_b, 0);
        end

        clr = 1'b0;
        k = 0;
        first_rise = -1; first_fall = -1; second_rise = -1;
        for (int i = 0; i < 1000; i++) begin
            int kk;
            kk = k;
            tick();
            check(a_hs == 1'b0, "R2 base variant hsync held low", a_hs, 0);
            if (b_hs && first_rise < 0) first_rise = kk;
            else if (!b_hs && first_rise >= 0 && first_fall < 0) first_fall = kk;
            else if (b_hs && first_fall >= 0 && second_rise < 0) second_rise = kk;
        end
        check(first_rise == 23, "R3 first hsync rise", first_rise, 23);
        check(first_fall - first_rise == 68, "R3 hsync width", first_fall - first_rise, 68);
        check(second_rise - first_rise == 910, "R3 line period", second_rise - first_rise, 910);

        // randomized configurations with forced corners
        for (int i = 0; i < 24; i++) begin
            mcfg_t c;
            c = rand_cfg();
            if (i == 3) c.eq = 1'b0;
            if (i == 4) c.eq = 1'b1;
            if (i == 5) c.il = 1'b0;
            if (i == 6) begin c.il = 1'b1; c.vt = c.vt | 1; end
            if (i == 7) c.gm = 1'b1;
            load(c);
            if (i == 9) begin
                c.run = 1'b0;
                load(c);
                tick();
                held = got_a;
                for (int j = 0; j < 100; j++) begin
                    tick();
                    check(got_a == held, "R12 outputs frozen while stopped", got_a, held);
                end
                c.run = 1'b1;
                load(c);
            end
            if (i == 11) begin
                // shorter line loaded while the counter sits near the old end
                for (int j = 0; j < c.ht - 2; j++) tick();
                c.ht = 16;
                c.hf = 1; c.hs = 4; c.hb = 6;
                load(c);
            end
            for (int j = 0; j < 1400; j++) tick();
        end

        // R1: clear mid-run restores defaults and stops the base variant
        clr = 1'b1;
        tick();
        check(got_a == '0, "R1 clear mid-run", got_a, 0);
        tick();
        clr = 1'b0;
        for (int j = 0; j < 60; j++) tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule